// File: doc/BRIEF.md
# Rotate, Shift and Bit Manipulation Unit

This unit performs the bit-level data operations of a small accumulator processor. It covers four kinds of rotate, three shifts, a nibble swap, and single-bit test, set and clear. Each cycle it accepts an operand byte, the current flag nibble (whose C bit is the incoming carry), a bit index, an operation code and a marker for the short accumulator rotate forms. One clock edge later it presents the result byte, the new flag nibble and a write-enable that tells the register file whether to store the result.

The unit sits after operand fetch and opcode decode. The surrounding pipeline supplies the operand from a register or from memory. It also maps the prefixed opcode onto the operation code listed below, and it writes the flags back every cycle. When an operation leaves a flag unchanged, the unit passes that flag through from its input.

The flag nibble is ordered {Z, N, H, C}, with Z at bit 3 and C at bit 0. The operation codes are: 0 circular left, 1 circular right, 2 left through carry, 3 right through carry, 4 arithmetic left shift, 5 arithmetic right shift, 6 logical right shift, 7 nibble swap, 8 bit test, 9 bit clear, 10 bit set. Codes 11 to 15 are unused.

Top module: `rsb_unit`

## Requirements
- R1: All outputs are registered, so a result appears one clock after its inputs. While rst_n is low, result_o, flags_o and wr_en_o are all 0. The flag layout is {Z,N,H,C} with Z at bit 3 and C at bit 0.
- R2: Codes 0 and 1 with the short marker low rotate the byte circularly left or right. C receives the bit rotated out, Z is set when the result is zero, N and H are 0, and wr_en_o is 1.
- R3: Codes 0 to 3 with the short marker high give the same result byte and C as their general forms, but force Z, N and H to 0.
- R4: Code 2 moves old bit 7 into C and the old carry into bit 0. Code 3 moves old bit 0 into C and the old carry into bit 7. For both, Z is set from the result and N and H are 0.
- R5: Code 4 shifts left with bit 0 filled with 0 and C taking old bit 7. Code 6 shifts right with bit 7 filled with 0 and C taking old bit 0. For both, Z is set from the result and N and H are 0.
- R6: Code 5 shifts right, keeps bit 7 unchanged and moves old bit 0 into C. Z is set from the result and N and H are 0.
- R7: Code 7 exchanges the upper and lower nibbles. Z is set from the result, and N, H and C are 0.
- R8: Code 8 sets Z when the indexed bit is 0, clears N, sets H and keeps C. wr_en_o is 0 and result_o equals the operand.
- R9: Codes 9 and 10 force the indexed bit to 0 or 1 respectively and set wr_en_o to 1. The flags equal the incoming flags.
- R10: The short marker has no effect for codes 4 to 15, and the bit index has no effect for codes 0 to 7.
- R11: Codes 11 to 15 give wr_en_o 0, result_o equal to the operand, and flags equal to the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| short_i | input | 1 | Marks the short accumulator rotate form |
| idx_i | input | 3 | Bit index for test, set and clear |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Current flags {Z,N,H,C}; C is the carry input |
| result_o | output | 8 | Result byte |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result should be stored |

## Verification
The short-form marker and a non-rotate operation can arrive in the same cycle. The bench provokes this by raising the marker together with an arithmetic left shift whose result is zero. The Z flag must still come out as 1, which shows the marker was ignored. The bit index can also arrive together with a rotate. The bench judges that case by comparing the rotate result against the value the same operand gives with index 0.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_RLC  = 4'd0;
  localparam logic [OPW-1:0] OP_RRC  = 4'd1;
  localparam logic [OPW-1:0] OP_RL   = 4'd2;
  localparam logic [OPW-1:0] OP_RR   = 4'd3;
  localparam logic [OPW-1:0] OP_SLA  = 4'd4;
  localparam logic [OPW-1:0] OP_SRA  = 4'd5;
  localparam logic [OPW-1:0] OP_SRL  = 4'd6;
  localparam logic [OPW-1:0] OP_SWAP = 4'd7;
  localparam logic [OPW-1:0] OP_BIT  = 4'd8;
  localparam logic [OPW-1:0] OP_RES  = 4'd9;
  localparam logic [OPW-1:0] OP_SET  = 4'd10;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } rsb_flags_t;

  function automatic logic [DW-1:0] swap_halves(input logic [DW-1:0] v);
    return {v[DW/2-1:0], v[DW-1:DW/2]};
  endfunction

  function automatic logic [DW-1:0] force_bit(input logic [DW-1:0] v,
                                              input logic [IW-1:0] pos,
                                              input logic val);
    logic [DW-1:0] r;
    r = v;
    r[pos] = val;
    return r;
  endfunction
endpackage

// File: rtl/rsb_shift_core.sv
module rsb_shift_core
  import rsb_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic           cin_i,
  output logic [DW-1:0]  res_o,
  output logic           cout_o,
  output logic           hit_o
);
  assign hit_o = (op_i[OPW-1:3] == '0);

  always_comb begin
    res_o  = opnd_i;
    cout_o = 1'b0;
    case (op_i)
      OP_RLC:  begin res_o = {opnd_i[DW-2:0], opnd_i[DW-1]}; cout_o = opnd_i[DW-1]; end
      OP_RRC:  begin res_o = {opnd_i[0], opnd_i[DW-1:1]};    cout_o = opnd_i[0];    end
      OP_RL:   begin res_o = {opnd_i[DW-2:0], cin_i};        cout_o = opnd_i[DW-1]; end
      OP_RR:   begin res_o = {cin_i, opnd_i[DW-1:1]};        cout_o = opnd_i[0];    end
      OP_SLA:  begin res_o = {opnd_i[DW-2:0], 1'b0};         cout_o = opnd_i[DW-1]; end
      OP_SRA:  begin res_o = {opnd_i[DW-1], opnd_i[DW-1:1]}; cout_o = opnd_i[0];    end
      OP_SRL:  begin res_o = {1'b0, opnd_i[DW-1:1]};         cout_o = opnd_i[0];    end
      OP_SWAP: begin res_o = swap_halves(opnd_i);            cout_o = 1'b0;         end
      default: begin res_o = opnd_i;                         cout_o = 1'b0;         end
    endcase
  end
endmodule

// File: rtl/rsb_bit_core.sv
module rsb_bit_core
  import rsb_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [DW-1:0]  opnd_i,
  output logic [DW-1:0]  res_o,
  output logic           sel_zero_o,
  output logic           test_o,
  output logic           modify_o
);
  assign test_o     = (op_i == OP_BIT);
  assign modify_o   = (op_i == OP_RES) || (op_i == OP_SET);
  assign sel_zero_o = ~opnd_i[idx_i];

  always_comb begin
    if (modify_o) res_o = force_bit(opnd_i, idx_i, op_i == OP_SET);
    else          res_o = opnd_i;
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op_i,
  input  logic           short_i,
  input  logic [2:0]     idx_i,
  input  logic [7:0]     opnd_i,
  input  logic [3:0]     flags_i,
  output logic [7:0]     result_o,
  output logic [3:0]     flags_o,
  output logic           wr_en_o
);
  logic [DW-1:0] sh_res, bt_res, nxt_res;
  logic          sh_c, sh_hit, bt_zero, bt_test, bt_mod;
  logic          short_form_w, nxt_wr;
  rsb_flags_t    fin, nxt_flags, flags_q;
  logic [DW-1:0] res_q;
  logic          wr_q;

  assign fin = rsb_flags_t'(flags_i);

  rsb_shift_core u_shift (
    .op_i(op_i), .opnd_i(opnd_i), .cin_i(fin.c),
    .res_o(sh_res), .cout_o(sh_c), .hit_o(sh_hit)
  );

  rsb_bit_core u_bit (
    .op_i(op_i), .idx_i(idx_i), .opnd_i(opnd_i),
    .res_o(bt_res), .sel_zero_o(bt_zero), .test_o(bt_test), .modify_o(bt_mod)
  );

  // short marker only counts for the four rotate codes
  assign short_form_w = short_i && (op_i[OPW-1:2] == '0);

  always_comb begin
    nxt_res   = opnd_i;
    nxt_flags = fin;
    nxt_wr    = 1'b0;
    if (sh_hit) begin
      nxt_res     = sh_res;
      nxt_wr      = 1'b1;
      nxt_flags.z = short_form_w ? 1'b0 : (sh_res == '0);
      nxt_flags.n = 1'b0;
      nxt_flags.h = 1'b0;
      nxt_flags.c = sh_c;
    end else if (bt_test) begin
      nxt_flags.z = bt_zero;
      nxt_flags.n = 1'b0;
      nxt_flags.h = 1'b1;
    end else if (bt_mod) begin
      nxt_res = bt_res;
      nxt_wr  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      res_q   <= nxt_res;
      flags_q <= nxt_flags;
      wr_q    <= nxt_wr;
    end
  end

  assign result_o = res_q;
  assign flags_o  = flags_q;
  assign wr_en_o  = wr_q;

  // R3
  short_rot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_i && op_i <= OP_RR) |=> (flags_o[3:1] == 3'b000 && wr_en_o));

  // R7
  swap_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SWAP) |=> (result_o == {$past(opnd_i[3:0]), $past(opnd_i[7:4])}
                           && flags_o[2:0] == 3'b000));

  // R8
  bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BIT) |=> (!wr_en_o && flags_o[2:1] == 2'b01
                          && flags_o[0] == $past(flags_i[0])
                          && result_o == $past(opnd_i)));

  // R9
  bit_modify_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SET || op_i == OP_RES) |=> (wr_en_o && flags_o == $past(flags_i)));

  // R11
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > OP_SET) |=> (!wr_en_o && flags_o == $past(flags_i)
                         && result_o == $past(opnd_i)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (!rst_n) |-> (result_o == '0 && flags_o == '0 && !wr_en_o));
endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic       short_i = 1'b0;
  logic [2:0] idx_i = '0;
  logic [7:0] opnd_i = '0;
  logic [3:0] flags_i = '0;
  logic [7:0] result_o;
  logic [3:0] flags_o;
  logic       wr_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsb_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .short_i(short_i), .idx_i(idx_i),
    .opnd_i(opnd_i), .flags_i(flags_i), .result_o(result_o),
    .flags_o(flags_o), .wr_en_o(wr_en_o)
  );

  // {op, short, idx, operand, flags in, result, flags out, wr, requirement}
  localparam int NV = 26;
  localparam logic [36:0] VECS [0:NV-1] = '{
    {4'd0, 1'b0, 3'd0, 8'h85, 4'h0, 8'h0B, 4'h1, 1'b1, 4'd2},   // R2 circular left
    {4'd0, 1'b0, 3'd0, 8'h00, 4'h1, 8'h00, 4'h8, 1'b1, 4'd2},   // R2 zero result
    {4'd0, 1'b1, 3'd0, 8'h00, 4'hF, 8'h00, 4'h0, 1'b1, 4'd3},   // R3 short, Z forced
    {4'd1, 1'b0, 3'd0, 8'h01, 4'h0, 8'h80, 4'h1, 1'b1, 4'd2},   // R2 circular right
    {4'd1, 1'b1, 3'd0, 8'h01, 4'h6, 8'h80, 4'h1, 1'b1, 4'd3},   // R3 short right
    {4'd2, 1'b0, 3'd0, 8'h80, 4'h1, 8'h01, 4'h1, 1'b1, 4'd4},   // R4 left, carry in 1
    {4'd2, 1'b0, 3'd0, 8'h80, 4'h0, 8'h00, 4'h9, 1'b1, 4'd4},   // R4 left, carry in 0
    {4'd3, 1'b0, 3'd0, 8'h01, 4'h0, 8'h00, 4'h9, 1'b1, 4'd4},   // R4 right, carry in 0
    {4'd3, 1'b0, 3'd0, 8'h02, 4'h1, 8'h81, 4'h0, 1'b1, 4'd4},   // R4 right, carry in 1
    {4'd2, 1'b1, 3'd0, 8'h80, 4'h0, 8'h00, 4'h1, 1'b1, 4'd3},   // R3 short through carry
    {4'd4, 1'b0, 3'd0, 8'hC1, 4'h1, 8'h82, 4'h1, 1'b1, 4'd5},   // R5 left shift
    {4'd4, 1'b0, 3'd0, 8'h80, 4'h0, 8'h00, 4'h9, 1'b1, 4'd5},   // R5 left shift to zero
    {4'd6, 1'b0, 3'd0, 8'h81, 4'h0, 8'h40, 4'h1, 1'b1, 4'd5},   // R5 logical right
    {4'd6, 1'b0, 3'd0, 8'h80, 4'h1, 8'h40, 4'h0, 1'b1, 4'd5},   // R5 logical right, C cleared
    {4'd5, 1'b0, 3'd0, 8'h81, 4'h0, 8'hC0, 4'h1, 1'b1, 4'd6},   // R6 sign kept
    {4'd5, 1'b0, 3'd0, 8'h01, 4'h0, 8'h00, 4'h9, 1'b1, 4'd6},   // R6 zero result
    {4'd7, 1'b0, 3'd0, 8'hA5, 4'h1, 8'h5A, 4'h0, 1'b1, 4'd7},   // R7 swap
    {4'd7, 1'b0, 3'd0, 8'h00, 4'h0, 8'h00, 4'h8, 1'b1, 4'd7},   // R7 swap zero
    {4'd8, 1'b0, 3'd3, 8'h08, 4'h1, 8'h08, 4'h3, 1'b0, 4'd8},   // R8 bit set, C kept
    {4'd8, 1'b0, 3'd7, 8'h7F, 4'hE, 8'h7F, 4'hA, 1'b0, 4'd8},   // R8 bit clear, C kept 0
    {4'd10, 1'b0, 3'd0, 8'h00, 4'hA, 8'h01, 4'hA, 1'b1, 4'd9},  // R9 set bit 0
    {4'd9, 1'b0, 3'd7, 8'hFF, 4'h5, 8'h7F, 4'h5, 1'b1, 4'd9},   // R9 clear bit 7
    {4'd4, 1'b1, 3'd5, 8'h80, 4'h0, 8'h00, 4'h9, 1'b1, 4'd10},  // R10 marker with shift
    {4'd0, 1'b0, 3'd6, 8'h85, 4'h0, 8'h0B, 4'h1, 1'b1, 4'd10},  // R10 index with rotate
    {4'd11, 1'b1, 3'd2, 8'h3C, 4'h6, 8'h3C, 4'h6, 1'b0, 4'd11}, // R11 unused code
    {4'd15, 1'b0, 3'd0, 8'h99, 4'h9, 8'h99, 4'h9, 1'b0, 4'd11}  // R11 unused code
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic sh, input logic [2:0] ix,
                       input logic [7:0] d, input logic [3:0] f);
    @(negedge clk);
    op_i = op; short_i = sh; idx_i = ix; opnd_i = d; flags_i = f;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(result_o == 8'h00, 1, "reset result", result_o, 8'h00);
    chk(flags_o == 4'h0, 1, "reset flags", {4'h0, flags_o}, 8'h00);
    chk(wr_en_o == 1'b0, 1, "reset wr", {7'h0, wr_en_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VECS[i];
      apply(v[36:33], v[32], v[31:29], v[28:21], v[20:17]);
      if (v[0 +: 5] != 0 && v[4] == 1'b1)
        chk(wr_en_o == v[4], int'(v[3:0]), "write enable", {7'h0, wr_en_o}, {7'h0, v[4]});
      else
        chk(wr_en_o == v[4], int'(v[3:0]), "write enable", {7'h0, wr_en_o}, {7'h0, v[4]});
      chk(result_o == v[16:9], int'(v[3:0]), "result", result_o, v[16:9]);
      chk(flags_o == v[8:5], int'(v[3:0]), "flags", {4'h0, flags_o}, {4'h0, v[8:5]});
    end

    // R1: one-cycle latency, the output holds the old value until the edge
    @(negedge clk);
    op_i = 4'd7; short_i = 1'b0; idx_i = 3'd0; opnd_i = 8'h12; flags_i = 4'h0;
    #1;
    chk(result_o == 8'h99, 1, "result before edge", result_o, 8'h99);
    @(posedge clk);
    #1;
    chk(result_o == 8'h21, 1, "result after edge", result_o, 8'h21);

    // R8: every bit position of a walking-zero operand
    for (int b = 0; b < 8; b++) begin
      logic [7:0] d;
      d = ~(8'h01 << b);
      apply(4'd8, 1'b0, 3'(b), d, 4'h0);
      chk(flags_o == 4'hA, 8, "test of a cleared bit", {4'h0, flags_o}, 8'h0A);
    end

    // R1: asynchronous reset during operation
    apply(4'd10, 1'b0, 3'd4, 8'h00, 4'hF);
    chk(result_o == 8'h10, 9, "set bit 4", result_o, 8'h10);
    #3;
    rst_n = 1'b0;
    #2;
    chk(result_o == 8'h00 && flags_o == 4'h0 && !wr_en_o, 1, "async reset",
        result_o, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule